// File: doc/BRIEF.md
# Multiplexed-Bus RAM and I/O Slave

This block is a byte-wide slave on a bus that carries the address and then the data over the same eight lines. It holds a 256-byte memory, three general-purpose ports (A and B are eight bits wide, C is six bits wide) and a configuration register. An access begins with an address-strobe pulse. At the strobe's falling edge the block captures three things together: the address, the chip-enable level and the memory/I-O select. The read or write strobe that follows then moves one byte. Its target is the memory or the register space, whichever the captured select named.

All inputs are synchronous to `clk`. The shared bus is split into `ad_in`, `ad_out` and `ad_oe`. Each port pin is split the same way into in, out and output-enable, and the direction comes from the configuration register. The bus has no valid/ready handshake and no back-pressure. A read is answered while the read strobe is held low, and a write is complete one clock after the write strobe rises. Port C can be set to a control arrangement, in which its low six bits take on the handshake roles of ports A and B. Only the pin directions of that arrangement are modelled.

Top module: `mbus_ram_io`

## Requirements
- R1: The address that applies to an access is the one on `ad_in` in the last clock cycle in which `ale` was sampled high. It is captured when `ale` is first sampled low, and later changes on `ad_in` do not alter it.
- R2: The chip-enable level (active-low when `CE_ACTIVE_HIGH` = 0, active-high when 1) is captured at the same falling edge of `ale`, and only that captured level gates the access. A write made with the captured enable inactive changes no state, and a change of `ce_sel` after the capture has no effect.
- R3: The captured `io_sel` = 0 directs the access to the 256×8 memory. The captured `io_sel` = 1 directs it to the register space.
- R4: `ad_oe` is 1 only while `rd_n` is 0 and the captured chip enable is active. When `ad_oe` is 0, `ad_out` is 0x00.
- R5: A write takes effect when `wr_n` rises. The byte written is the one on `ad_in` in the last cycle `wr_n` was low, and it is visible one clock later. No target changes while `wr_n` stays level.
- R6: While `rst` is high, the configuration register and the port output latches are cleared to zero, so every port is an input (all `*_oe` bits are 0).
- R7: The register space is decoded as follows: 0x00 is configuration on write and status on read, 0x01 is port A, 0x02 is port B and 0x03 is port C. Any other register address reads 0x00, and writes to it are ignored.
- R8: The configuration byte is laid out as follows. Bit 0 = 1 makes all of port A an output, and bit 1 = 1 does the same for port B. Bits 3:2 set the port C mode. A status read returns bits 3:0 of the configuration, with zeros above.
- R9: The port C mode sets the direction of its six pins. With 00 all pins are inputs, and with 11 all are outputs. With 01 only bit 2, the port A strobe, is an input. With 10 bits 2 and 5, the A and B strobes, are inputs and bits 0, 1, 3 and 4 (interrupt and buffer-full lines) are outputs.
- R10: A port read returns, bit by bit, the output latch where that bit is an output and the live pin where it is an input. The upper bits of a port C read are zero.
- R11: The memory holds all 256 bytes, from 0x00 through 0xFF, and is separate from the register space. A register write never alters a memory byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are synchronous to it |
| rst | input | 1 | Active-high synchronous reset |
| ale | input | 1 | Address strobe; falling edge captures address, enable and select |
| ce_sel | input | 1 | Chip enable, polarity set by `CE_ACTIVE_HIGH` |
| io_sel | input | 1 | 0 = memory, 1 = register space |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Multiplexed address/data from the bus |
| ad_out | output | 8 | Read data onto the bus |
| ad_oe | output | 1 | Bus driver enable |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A pin drive enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B pin drive enables |
| pc_in | input | 6 | Port C pin levels |
| pc_out | output | 6 | Port C output latch |
| pc_oe | output | 6 | Port C pin drive enables |

## Verification
A wrong captured address or select appears at the first read that follows. That read returns a byte from the wrong location or the wrong space, so every write is read back over the bus. A corrupt configuration register shows at once on the `*_oe` pins, in the clock after the write edge, and also on the next status read. A chip enable or select taken live instead of captured is exposed by dropping `ce_sel` right after the address phase: a captured design still answers, and a live-sampling one falls silent in that same access.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [1:0] {
    PC_ALL_IN  = 2'b00,
    PC_CTL_A   = 2'b01,
    PC_CTL_AB  = 2'b10,
    PC_ALL_OUT = 2'b11
  } pc_mode_e;

  // Configuration byte, low nibble: {pc_mode[3:2], pb_dir[1], pa_dir[0]}
  typedef struct packed {
    pc_mode_e pc_mode;
    logic     pb_dir;
    logic     pa_dir;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // Register-space offsets
  localparam int unsigned REG_CFG = 0;
  localparam int unsigned REG_PA  = 1;
  localparam int unsigned REG_PB  = 2;
  localparam int unsigned REG_PC  = 3;

  // Port C handshake bit roles
  localparam int PC_A_STB = 2;
  localparam int PC_B_STB = 5;

endpackage

// File: rtl/mbus_latch.sv
module mbus_latch #(
  parameter int ADDR_W         = 8,
  parameter int DATA_W         = 8,
  parameter bit CE_ACTIVE_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              ce_sel,
  input  logic              io_sel,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic              ce_q,
  output logic              io_q,
  output logic              wr_commit,
  output logic [DATA_W-1:0] wr_data
);

  logic              ce_act;
  logic              ale_q;
  logic              wr_q;
  logic [DATA_W-1:0] ad_d;
  logic              ce_d;
  logic              io_d;

  generate
    if (CE_ACTIVE_HIGH) begin : g_ce_hi
      assign ce_act = ce_sel;
    end else begin : g_ce_lo
      assign ce_act = ~ce_sel;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q  <= 1'b0;
      wr_q   <= 1'b1;
      ad_d   <= '0;
      ce_d   <= 1'b0;
      io_d   <= 1'b0;
      addr_q <= '0;
      ce_q   <= 1'b0;
      io_q   <= 1'b0;
    end else begin
      ale_q <= ale;
      wr_q  <= wr_n;
      ad_d  <= ad_in;
      ce_d  <= ce_act;
      io_d  <= io_sel;
      if (ale_q && !ale) begin
        addr_q <= ad_d[ADDR_W-1:0];
        ce_q   <= ce_d;
        io_q   <= io_d;
      end
    end
  end

  // Rising edge of the write strobe; data is the byte seen while it was low
  assign wr_commit = ~wr_q & wr_n;
  assign wr_data   = ad_d;

endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/mbus_ioregs.sv
module mbus_ioregs
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PC_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pa_in,
  input  logic [DATA_W-1:0] pb_in,
  input  logic [PC_W-1:0]   pc_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_oe,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   pc_oe,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [PC_W-1:0] A_STB_M = PC_W'(1) << PC_A_STB;
  localparam logic [PC_W-1:0] B_STB_M = PC_W'(1) << PC_B_STB;

  cfg_t cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      pa_out <= '0;
      pb_out <= '0;
      pc_out <= '0;
    end else if (we) begin
      case (addr)
        ADDR_W'(REG_CFG): cfg    <= cfg_t'(wdata[CFG_W-1:0]);
        ADDR_W'(REG_PA):  pa_out <= wdata;
        ADDR_W'(REG_PB):  pb_out <= wdata;
        ADDR_W'(REG_PC):  pc_out <= wdata[PC_W-1:0];
        default: ;
      endcase
    end
  end

  assign pa_oe = {DATA_W{cfg.pa_dir}};
  assign pb_oe = {DATA_W{cfg.pb_dir}};

  always_comb begin
    case (cfg.pc_mode)
      PC_ALL_IN:  pc_oe = '0;
      PC_CTL_A:   pc_oe = ~A_STB_M;
      PC_CTL_AB:  pc_oe = ~(A_STB_M | B_STB_M);
      default:    pc_oe = '1;
    endcase
  end

  always_comb begin
    case (addr)
      ADDR_W'(REG_CFG): rdata = DATA_W'(cfg);
      ADDR_W'(REG_PA):  rdata = (pa_out & pa_oe) | (pa_in & ~pa_oe);
      ADDR_W'(REG_PB):  rdata = (pb_out & pb_oe) | (pb_in & ~pb_oe);
      ADDR_W'(REG_PC):  rdata = DATA_W'((pc_out & pc_oe) | (pc_in & ~pc_oe));
      default:          rdata = '0;
    endcase
  end

endmodule

// File: rtl/mbus_ram_io.sv
module mbus_ram_io #(
  parameter int ADDR_W         = 8,
  parameter int DATA_W         = 8,
  parameter int PC_W           = 6,
  parameter bit CE_ACTIVE_HIGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale,
  input  logic              ce_sel,
  input  logic              io_sel,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_oe,
  input  logic [PC_W-1:0]   pc_in,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   pc_oe
);

  logic [ADDR_W-1:0] addr_q;
  logic              ce_q;
  logic              io_q;
  logic              wr_commit;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              mem_we;
  logic              reg_we;

  mbus_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CE_ACTIVE_HIGH(CE_ACTIVE_HIGH)
  ) u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ce_sel(ce_sel), .io_sel(io_sel),
    .wr_n(wr_n), .ad_in(ad_in), .addr_q(addr_q), .ce_q(ce_q), .io_q(io_q),
    .wr_commit(wr_commit), .wr_data(wr_data)
  );

  assign mem_we = wr_commit & ce_q & ~io_q;
  assign reg_we = wr_commit & ce_q & io_q;

  mbus_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(mem_we), .addr(addr_q), .wdata(wr_data), .rdata(mem_rdata)
  );

  mbus_ioregs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PC_W(PC_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(addr_q), .wdata(wr_data),
    .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
    .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_out(pc_out), .pc_oe(pc_oe), .rdata(reg_rdata)
  );

  assign ad_oe  = ~rd_n & ce_q;
  assign ad_out = ad_oe ? (io_q ? reg_rdata : mem_rdata) : '0;

endmodule

// File: rtl/mbus_ram_io_chk.sv
module mbus_ram_io_chk #(
  parameter int DATA_W = 8,
  parameter int PC_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_n,
  input logic              wr_n,
  input logic              ad_oe,
  input logic [DATA_W-1:0] pa_out,
  input logic [DATA_W-1:0] pa_oe,
  input logic [DATA_W-1:0] pb_oe,
  input logic [PC_W-1:0]   pc_oe
);

  p_drive_only_on_read_r4: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !rd_n);

  p_inputs_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0));

  p_whole_port_dir_r8: assert property (@(posedge clk) disable iff (rst)
    (pa_oe == '0 || pa_oe == '1) && (pb_oe == '0 || pb_oe == '1));

  p_latch_holds_r5: assert property (@(posedge clk) disable iff (rst)
    $stable(wr_n) |=> $stable(pa_out));

  p_strobe_in_ctl_r9: assert property (@(posedge clk) disable iff (rst)
    pc_oe[2] |-> (pc_oe == '1));

endmodule

bind mbus_ram_io mbus_ram_io_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/mbus_ram_io_tb_top.sv
module mbus_ram_io_tb_top;

  localparam logic CE_ON = 1'b0;  // default variant: enable active-low

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0;
  logic       ce_sel = ~CE_ON;
  logic       io_sel = 1'b0;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ad_out;
  logic       ad_oe;
  logic [7:0] pa_in = 8'h5A;
  logic [7:0] pa_out, pa_oe;
  logic [7:0] pb_in = 8'hC3;
  logic [7:0] pb_out, pb_oe;
  logic [5:0] pc_in = 6'h12;
  logic [5:0] pc_out, pc_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mbus_ram_io dut_i (
    .clk(clk), .rst(rst), .ale(ale), .ce_sel(ce_sel), .io_sel(io_sel),
    .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // address phase; enable is dropped afterwards so only the captured level counts
  task automatic addr_phase(logic io, logic [7:0] a, logic ce_on);
    @(negedge clk);
    ale = 1'b1; ad_in = a; io_sel = io; ce_sel = ce_on ? CE_ON : ~CE_ON;
    @(negedge clk);
    ale = 1'b0; ad_in = 8'h00; ce_sel = ~CE_ON; io_sel = ~io;
  endtask

  task automatic do_write(logic io, logic [7:0] a, logic [7:0] d, logic ce_on);
    addr_phase(io, a, ce_on);
    @(negedge clk); ad_in = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; ad_in = 8'h00;
    @(negedge clk);
  endtask

  task automatic do_read(logic io, logic [7:0] a, logic ce_on,
                         output logic [7:0] d, output logic oe);
    addr_phase(io, a, ce_on);
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); d = ad_out; oe = ad_oe; rd_n = 1'b1;
  endtask

  // {write, io, addr, data or expected, requirement}
  localparam int NV = 23;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h00, 8'h11, 4'd3},   // R3 memory write
    {1'b1, 1'b0, 8'hFF, 8'hEE, 4'd11},  // R11 top byte
    {1'b1, 1'b0, 8'h01, 8'h77, 4'd11},
    {1'b0, 1'b0, 8'h00, 8'h11, 4'd3},   // R3
    {1'b0, 1'b0, 8'hFF, 8'hEE, 4'd1},   // R1 captured address used
    {1'b0, 1'b1, 8'h01, 8'h5A, 4'd10},  // R10 input port reads pins
    {1'b1, 1'b1, 8'h00, 8'h03, 4'd8},   // R8 A,B outputs
    {1'b1, 1'b1, 8'h01, 8'hA5, 4'd5},   // R5
    {1'b1, 1'b1, 8'h02, 8'h3C, 4'd5},
    {1'b0, 1'b1, 8'h01, 8'hA5, 4'd10},  // R10 output latch
    {1'b0, 1'b1, 8'h02, 8'h3C, 4'd10},
    {1'b0, 1'b1, 8'h00, 8'h03, 4'd8},   // R8 status
    {1'b0, 1'b0, 8'h01, 8'h77, 4'd11},  // R11 reg write kept memory
    {1'b1, 1'b1, 8'h07, 8'hFF, 4'd7},   // R7 ignored
    {1'b0, 1'b1, 8'h07, 8'h00, 4'd7},   // R7 reads zero
    {1'b0, 1'b1, 8'h00, 8'h03, 4'd7},   // R7 config untouched
    {1'b1, 1'b1, 8'h03, 8'h3F, 4'd9},
    {1'b0, 1'b1, 8'h03, 8'h12, 4'd9},   // R9 mode 00 pins
    {1'b1, 1'b1, 8'h00, 8'h08, 4'd9},   // R9 mode 10
    {1'b0, 1'b1, 8'h03, 8'h1B, 4'd9},   // R9 strobes 2,5 from pins
    {1'b0, 1'b1, 8'h01, 8'h5A, 4'd10},  // R10 A back to input
    {1'b1, 1'b1, 8'h00, 8'h04, 4'd9},   // R9 mode 01
    {1'b0, 1'b1, 8'h03, 8'h3B, 4'd9}    // R9 only bit 2 from pin
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    chk("R6 oe after reset", {pa_oe, pb_oe, 2'b00, pc_oe}, 24'h0);
    chk("R4 idle bus", {7'd0, ad_oe, ad_out}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      if (v[21]) begin
        do_write(v[20], v[19:12], v[11:4], 1'b1);
      end else begin
        do_read(v[20], v[19:12], 1'b1, d, oe);
        chk($sformatf("R%0d vec %0d", v[3:0], i), {oe, d}, {1'b1, v[11:4]});
      end
    end

    // R9 / R8 pin directions after mode 01, A and B inputs
    chk("R9 pc_oe mode 01", pc_oe, 6'h3B);
    chk("R8 pa_oe input", pa_oe, 8'h00);
    chk("R5 pb latch", pb_out, 8'h3C);

    // R2 write with captured enable inactive changes nothing
    do_write(1'b0, 8'h00, 8'h99, 1'b0);
    do_read(1'b0, 8'h00, 1'b1, d, oe);
    chk("R2 masked write", {oe, d}, {1'b1, 8'h11});
    // R4 read with enable inactive leaves bus undriven
    do_read(1'b0, 8'h00, 1'b0, d, oe);
    chk("R4 no drive", {oe, d}, 9'h000);

    // R8 / R9 all outputs
    do_write(1'b1, 8'h00, 8'h0F, 1'b1);
    chk("R8 all out", {pa_oe, pb_oe, 2'b00, pc_oe}, 24'hFFFF3F);

    // R6 reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R6 oe cleared", {pa_oe, pb_oe, 2'b00, pc_oe}, 24'h0);
    chk("R6 latches cleared", {pa_out, pb_out, 2'b00, pc_out}, 24'h0);
    do_read(1'b1, 8'h00, 1'b1, d, oe);
    chk("R6 status zero", {oe, d}, 9'h100);

    done = 1'b1;
    finish_run();
  end

endmodule